// File: doc/BRIEF.md
# ADC Conversion Sequencer with Software, Hardware and PWM Triggers

This block sits between an 8-bit special-function-register bus of a small CPU and a four-input, 10-bit successive-approximation converter macro. It runs one conversion per trigger. The trigger can be a write to a start register, a rising edge on an external trigger pin, or a period event from one of two PWM channels. PWM events let sampling follow the PWM period without any CPU action.

A divider built from the system clock makes the conversion clock, and software picks its rate. The block drives the converter's start strobe and channel select, then waits for end-of-conversion. It stores the sample in two result registers as either a full 10-bit value or an 8-bit value. When the sample is stored, a done flag is set, and an interrupt is raised if interrupts are enabled.

Register map (3-bit address): 0 control, 1 status, 2 start, 3 result high, 4 result low, 5 PWM trigger setup. Addresses 6 and 7 read as zero.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `adc_start` is low. Addresses 6 and 7 always read 0.
- R2: The control register (address 0) reads back bits 6:0 as written. Bit 7 always reads 0.
- R3: `adc_clk` is a free-running square wave. Its period is 2^(d+1) system cycles, where d is control bits 4:3.
- R4: In software mode (control bit 0 = 0), writing 1 to bit 0 of the start register (address 2) starts one conversion. That bit reads 0 again once the conversion is launched. In hardware mode (control bit 0 = 1), writes to the start register are ignored.
- R5: In hardware mode, a rising edge on `hw_trig` starts one conversion. In software mode, `hw_trig` is ignored.
- R6: Address 5 bit 0 enables PWM triggering, and bit 1 selects the PWM channel. A pulse on `pwm_evt[sel]` starts a conversion in either mode. Events on the other channel are ignored, and so are all events while bit 0 is 0.
- R7: A launch drives `adc_start` high for exactly one cycle. During that cycle, `adc_chan` equals control bits 2:1. Status bit 1 (busy) is high from the launch until end-of-conversion is accepted.
- R8: Triggers of any kind that arrive while busy are ignored, including a start-register write.
- R9: In 10-bit format (control bit 5 = 0), result high (address 3) reads {000000, d[9:8]} and result low (address 4) reads d[7:0].
- R10: In 8-bit format (control bit 5 = 1), result high reads d[9:2] and result low reads {d[1:0], 000000}.
- R11: Status bit 0 (done) is set when end-of-conversion is accepted. It is cleared by writing 0 to status bit 0 and by the launch of a new conversion. Writing 1 to it has no effect.
- R12: `irq` is high exactly when done is set and control bit 6 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 3 | Register address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data for `sfr_addr` |
| hw_trig | input | 1 | External trigger; rising edge starts a conversion in hardware mode |
| pwm_evt | input | 2 | One-cycle period events from the two PWM channels |
| adc_clk | output | 1 | Divided conversion clock to the converter |
| adc_start | output | 1 | One-cycle start strobe to the converter |
| adc_chan | output | 2 | Analog input select to the converter |
| adc_eoc | input | 1 | One-cycle end-of-conversion from the converter |
| adc_data | input | 10 | Conversion result, valid with `adc_eoc` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 4 channels, 10-bit results, 8-bit registers, two PWM channels and a 2-bit divider select. All four divide ratios (/2 to /16) can therefore be measured. At /16, the stub converter keeps the block busy for about 200 cycles, which leaves room to inject competing triggers. The 2-bit gap between the 10-bit result and the 8-bit register makes both the truncating and the split result layouts visible on the bus.

// File: rtl/adc_seq_pkg.sv
// Shared constants and types for the ADC conversion sequencer.
// Assumes a 3-bit register address space.
package adc_seq_pkg;

    // Register addresses
    localparam int ADR_CTRL  = 0;
    localparam int ADR_STAT  = 1;
    localparam int ADR_START = 2;
    localparam int ADR_RESHI = 3;
    localparam int ADR_RESLO = 4;
    localparam int ADR_PWMT  = 5;

    // Conversion sequencer states
    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_LAUNCH = 2'd1,
        CS_WAIT   = 2'd2
    } conv_state_e;

endpackage

// File: rtl/adc_clkdiv.sv
// Conversion clock divider.
// Produces a square wave whose period is 2^(div_sel+1) clk cycles.
// Assumes that a change of div_sel may shorten or stretch one half period.
module adc_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             conv_clk
);
    localparam int CNT_W = 2 ** SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    // Number of clk cycles per half period, minus one
    assign half_m1 = (CNT_W'(1) << div_sel) - CNT_W'(1);

    // Count a half period, then toggle the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            conv_clk <= 1'b0;
        end else if (cnt_q >= half_m1) begin
            cnt_q    <= '0;
            conv_clk <= ~conv_clk;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/adc_trig_sel.sv
// Trigger source selection.
// Merges the start-register request, the external trigger edge and the
// selected PWM event into one trigger pulse.
// Assumes PWM events are single-cycle pulses synchronous to clk.
module adc_trig_sel #(
    parameter int NUM_PWM = 2,
    parameter int PSEL_W  = $clog2(NUM_PWM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_mode,
    input  logic               sw_start,
    input  logic               hw_trig,
    input  logic               pwm_en,
    input  logic [PSEL_W-1:0]  pwm_sel,
    input  logic [NUM_PWM-1:0] pwm_evt,
    output logic               trig
);
    logic               hw_q;
    logic               hw_rise;
    logic [NUM_PWM-1:0] pwm_hit;

    // Remember the previous external trigger level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hw_q <= 1'b0;
        else        hw_q <= hw_trig;
    end

    assign hw_rise = hw_trig & ~hw_q;

    // Keep only the event of the selected PWM channel
    for (genvar i = 0; i < NUM_PWM; i++) begin : g_pwm
        assign pwm_hit[i] = pwm_evt[i] & (pwm_sel == PSEL_W'(i));
    end

    // The mode picks software or hardware; PWM works in either mode
    always_comb begin
        trig = (hw_mode ? hw_rise : sw_start) | (pwm_en & (|pwm_hit));
    end
endmodule

// File: rtl/adc_conv_fsm.sv
// Conversion handshake sequencer.
// Leaves idle on a trigger, strobes the converter start for one cycle,
// then waits for end-of-conversion. Triggers are not looked at while busy.
module adc_conv_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic eoc,
    output logic launch,
    output logic capture,
    output logic busy,
    output logic conv_start
);
    import adc_seq_pkg::*;

    conv_state_e state_q;
    conv_state_e state_d;

    // Next-state logic of the handshake
    always_comb begin
        state_d = state_q;
        case (state_q)
            CS_IDLE:   if (trig) state_d = CS_LAUNCH;
            CS_LAUNCH: state_d = CS_WAIT;
            CS_WAIT:   if (eoc) state_d = CS_IDLE;
            default:   state_d = CS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    assign launch     = (state_q == CS_IDLE) && trig;
    assign capture    = (state_q == CS_WAIT) && eoc;
    assign busy       = (state_q != CS_IDLE);
    assign conv_start = (state_q == CS_LAUNCH);
endmodule

// File: rtl/adc_result_fmt.sv
// Result formatter.
// Maps a RES_W-bit sample onto two DATA_W-bit registers, either split
// (full precision) or left-aligned (truncated high byte).
// Assumes DATA_W < RES_W < 2*DATA_W.
module adc_result_fmt #(
    parameter int RES_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic [RES_W-1:0]  sample,
    input  logic              fmt_short,
    output logic [DATA_W-1:0] hi_byte,
    output logic [DATA_W-1:0] lo_byte
);
    localparam int EXTRA = RES_W - DATA_W;

    // Select the layout of both result bytes
    always_comb begin
        if (fmt_short) begin
            hi_byte = sample[RES_W-1:EXTRA];
            lo_byte = {sample[EXTRA-1:0], {(DATA_W-EXTRA){1'b0}}};
        end else begin
            hi_byte = DATA_W'(sample[RES_W-1:DATA_W]);
            lo_byte = sample[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC conversion sequencer, top level.
// Holds the register file and connects the clock divider, the trigger
// selection, the handshake sequencer and the result formatter.
// Assumes a single-cycle register bus with combinational read data and
// a converter that returns one eoc pulse per start strobe.
module adc_seq_ctrl #(
    parameter int CH_W    = 2,
    parameter int RES_W   = 10,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3,
    parameter int NUM_PWM = 2,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  sfr_addr,
    input  logic               sfr_wr,
    input  logic [DATA_W-1:0]  sfr_wdata,
    output logic [DATA_W-1:0]  sfr_rdata,
    input  logic               hw_trig,
    input  logic [NUM_PWM-1:0] pwm_evt,
    output logic               adc_clk,
    output logic               adc_start,
    output logic [CH_W-1:0]    adc_chan,
    input  logic               adc_eoc,
    input  logic [RES_W-1:0]   adc_data,
    output logic               irq
);
    import adc_seq_pkg::*;

    localparam int PSEL_W  = $clog2(NUM_PWM);
    localparam int CH_LSB  = 1;
    localparam int DIV_LSB = CH_LSB + CH_W;
    localparam int FMT_BIT = DIV_LSB + SEL_W;
    localparam int IEN_BIT = FMT_BIT + 1;

    // Control fields
    logic              mode_q;
    logic [CH_W-1:0]   chan_q;
    logic [SEL_W-1:0]  div_q;
    logic              fmt_q;
    logic              ien_q;
    // PWM trigger setup
    logic              pwm_en_q;
    logic [PSEL_W-1:0] pwm_sel_q;
    // Status, start and results
    logic              start_q;
    logic              done_q;
    logic [DATA_W-1:0] res_hi_q;
    logic [DATA_W-1:0] res_lo_q;

    logic wr_ctrl, wr_stat, wr_start, wr_pwmt;
    logic trig, launch, capture, conv_busy;
    logic [DATA_W-1:0] fmt_hi, fmt_lo;
    logic unused_wdata;

    assign wr_ctrl  = sfr_wr && (sfr_addr == ADDR_W'(ADR_CTRL));
    assign wr_stat  = sfr_wr && (sfr_addr == ADDR_W'(ADR_STAT));
    assign wr_start = sfr_wr && (sfr_addr == ADDR_W'(ADR_START));
    assign wr_pwmt  = sfr_wr && (sfr_addr == ADDR_W'(ADR_PWMT));
    assign unused_wdata = ^sfr_wdata[DATA_W-1:IEN_BIT+1];

    // Control register fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            chan_q <= '0;
            div_q  <= '0;
            fmt_q  <= 1'b0;
            ien_q  <= 1'b0;
        end else if (wr_ctrl) begin
            mode_q <= sfr_wdata[0];
            chan_q <= sfr_wdata[DIV_LSB-1:CH_LSB];
            div_q  <= sfr_wdata[FMT_BIT-1:DIV_LSB];
            fmt_q  <= sfr_wdata[FMT_BIT];
            ien_q  <= sfr_wdata[IEN_BIT];
        end
    end

    // PWM trigger setup register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_en_q  <= 1'b0;
            pwm_sel_q <= '0;
        end else if (wr_pwmt) begin
            pwm_en_q  <= sfr_wdata[0];
            pwm_sel_q <= sfr_wdata[PSEL_W:1];
        end
    end

    // Start request: accepted only in software mode when idle, cleared on launch
    always_ff @(posedge clk) begin
        if (!rst_n)                               start_q <= 1'b0;
        else if (launch)                          start_q <= 1'b0;
        else if (wr_start && !mode_q && !conv_busy) start_q <= sfr_wdata[0];
    end

    // Done flag: set on capture, cleared on launch or by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)                          done_q <= 1'b0;
        else if (capture)                    done_q <= 1'b1;
        else if (launch)                     done_q <= 1'b0;
        else if (wr_stat && !sfr_wdata[0])   done_q <= 1'b0;
    end

    // Result registers, loaded when the conversion is captured
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi_q <= '0;
            res_lo_q <= '0;
        end else if (capture) begin
            res_hi_q <= fmt_hi;
            res_lo_q <= fmt_lo;
        end
    end

    // Read data multiplexer
    always_comb begin
        sfr_rdata = '0;
        case (sfr_addr)
            ADDR_W'(ADR_CTRL):  sfr_rdata = DATA_W'({ien_q, fmt_q, div_q, chan_q, mode_q});
            ADDR_W'(ADR_STAT):  sfr_rdata = DATA_W'({conv_busy, done_q});
            ADDR_W'(ADR_START): sfr_rdata = DATA_W'(start_q);
            ADDR_W'(ADR_RESHI): sfr_rdata = res_hi_q;
            ADDR_W'(ADR_RESLO): sfr_rdata = res_lo_q;
            ADDR_W'(ADR_PWMT):  sfr_rdata = DATA_W'({pwm_sel_q, pwm_en_q});
            default:            sfr_rdata = '0;
        endcase
    end

    adc_clkdiv #(.SEL_W(SEL_W)) i_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_q),
        .conv_clk (adc_clk)
    );

    adc_trig_sel #(.NUM_PWM(NUM_PWM), .PSEL_W(PSEL_W)) i_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_mode  (mode_q),
        .sw_start (start_q),
        .hw_trig  (hw_trig),
        .pwm_en   (pwm_en_q),
        .pwm_sel  (pwm_sel_q),
        .pwm_evt  (pwm_evt),
        .trig     (trig)
    );

    adc_conv_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .eoc        (adc_eoc),
        .launch     (launch),
        .capture    (capture),
        .busy       (conv_busy),
        .conv_start (adc_start)
    );

    adc_result_fmt #(.RES_W(RES_W), .DATA_W(DATA_W)) i_fmt (
        .sample    (adc_data),
        .fmt_short (fmt_q),
        .hi_byte   (fmt_hi),
        .lo_byte   (fmt_lo)
    );

    assign adc_chan = chan_q;
    assign irq      = done_q & ien_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Assertion checker for the ADC conversion sequencer, bound to the top.
// Assumes the synchronous active-low reset of the top.
module adc_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic adc_start,
    input logic adc_eoc,
    input logic busy,
    input logic done_q,
    input logic start_q,
    input logic irq
);
    // R7: the start strobe lasts one cycle
    a_r7_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R7: busy rises together with the start strobe
    a_r7_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> adc_start);

    // R8: a launch only follows an idle cycle
    a_r8_launch_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !$past(busy));

    // R4: the start request is gone once launched
    a_r4_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !start_q);

    // R11: launch clears done
    a_r11_done_clear_launch: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !done_q);

    // R11: accepted end-of-conversion sets done
    a_r11_done_on_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !adc_start && adc_eoc) |=> done_q);

    // R12: no interrupt without done
    a_r12_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_q);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_start (adc_start),
    .adc_eoc   (adc_eoc),
    .busy      (conv_busy),
    .done_q    (done_q),
    .start_q   (start_q),
    .irq       (irq)
);

// File: tb/test_adc_seq_ctrl.sv
// Scoreboard bench for the ADC conversion sequencer with a converter stub.
module test_adc_seq_ctrl;
    localparam int CONV_EDGES = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sfr_addr = '0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = '0;
    logic [7:0] sfr_rdata;
    logic       hw_trig = 1'b0;
    logic [1:0] pwm_evt = '0;
    logic       adc_clk, adc_start, irq;
    logic [1:0] adc_chan;
    logic       adc_eoc = 1'b0;
    logic [9:0] adc_data = '0;

    int checks = 0;
    int failures = 0;
    int exp_idx = 0;

    typedef struct { logic [7:0] hi; logic [7:0] lo; } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .hw_trig(hw_trig),
        .pwm_evt(pwm_evt), .adc_clk(adc_clk), .adc_start(adc_start),
        .adc_chan(adc_chan), .adc_eoc(adc_eoc), .adc_data(adc_data), .irq(irq)
    );

    function automatic logic [9:0] stub_value(int ch, int idx);
        return 10'((ch * 211 + idx * 37 + 5) % 1024);
    endfunction

    // Converter stub: latch the channel on start, count conversion-clock edges, pulse eoc
    logic stub_run = 1'b0;
    logic clk_prev = 1'b0;
    int   stub_edges = 0;
    int   stub_idx = 0;
    int   stub_ch = 0;
    always @(posedge clk) begin
        clk_prev <= adc_clk;
        adc_eoc  <= 1'b0;
        if (!rst_n) begin
            stub_run <= 1'b0;
        end else if (!stub_run) begin
            if (adc_start) begin
                stub_run   <= 1'b1;
                stub_edges <= 0;
                stub_ch    <= int'(adc_chan);
            end
        end else if (adc_clk && !clk_prev) begin
            if (stub_edges == CONV_EDGES - 1) begin
                stub_run <= 1'b0;
                adc_eoc  <= 1'b1;
                adc_data <= stub_value(stub_ch, stub_idx);
                stub_idx <= stub_idx + 1;
            end else begin
                stub_edges <= stub_edges + 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic sfr_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        sfr_addr = a;
        #1 d = sfr_rdata;
    endtask

    function automatic logic [7:0] ctrl_byte(bit mode, int ch, int dv, bit f8, bit ien);
        return {1'b0, ien, f8, 2'(dv), 2'(ch), mode};
    endfunction

    // Driver side: push the expected result bytes for the next conversion
    task automatic push_expect(int ch, bit f8);
        logic [9:0] d;
        exp_t e;
        d = stub_value(ch, exp_idx);
        exp_idx++;
        if (f8) begin e.hi = d[9:2]; e.lo = {d[1:0], 6'b0}; end
        else    begin e.hi = {6'b0, d[9:8]}; e.lo = d[7:0]; end
        sb_q.push_back(e);
    endtask

    // Monitor side: wait for done, read the result bytes, compare with the queue
    task automatic monitor_result(string req);
        logic [7:0] st, hi, lo;
        exp_t e;
        st = '0;
        for (int n = 0; n < 2000; n++) begin
            sfr_read(3'd1, st);
            if (st[0]) break;
        end
        check({req, " done"}, st[0], 1);
        sfr_read(3'd3, hi);
        sfr_read(3'd4, lo);
        if (sb_q.size() == 0) begin
            check({req, " queue"}, 0, 1);
        end else begin
            e = sb_q.pop_front();
            check({req, " hi"}, hi, e.hi);
            check({req, " lo"}, lo, e.lo);
        end
    endtask

    task automatic pulse_pwm(logic [1:0] m);
        @(negedge clk); pwm_evt = m;
        @(negedge clk); pwm_evt = '0;
    endtask

    task automatic pulse_hw();
        @(negedge clk); hw_trig = 1'b1;
        repeat (3) @(negedge clk);
        hw_trig = 1'b0;
    endtask

    task automatic expect_idle_no_done(string req);
        logic [7:0] st;
        repeat (400) @(negedge clk);
        sfr_read(3'd1, st);
        check(req, st, 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", irq, 0);
        check("R1 adc_start", adc_start, 0);
        for (int a = 0; a < 8; a++) begin
            sfr_read(3'(a), v);
            check("R1 reg", v, 0);
        end

        // R2: control readback
        sfr_write(3'd0, 8'h5B); sfr_read(3'd0, v); check("R2 ctrl", v, 8'h5B);
        sfr_write(3'd0, 8'hFF); sfr_read(3'd0, v); check("R2 ctrl bit7", v, 8'h7F);

        // R3: conversion clock period per divider setting
        for (int d = 0; d < 4; d++) begin
            int cnt;
            logic prev;
            sfr_write(3'd0, ctrl_byte(0, 0, d, 0, 0));
            for (int k = 0; k < 2; k++) begin
                prev = adc_clk;
                do begin @(negedge clk); if (!prev && adc_clk) break; prev = adc_clk; end while (1);
            end
            cnt = 0; prev = adc_clk;
            do begin @(negedge clk); cnt++; if (!prev && adc_clk) break; prev = adc_clk; end while (1);
            check("R3 period", cnt, 2 << d);
        end

        // R4, R7, R9, R12: software start, 10-bit, channel 1
        sfr_write(3'd0, ctrl_byte(0, 1, 0, 0, 1));
        push_expect(1, 0);
        sfr_write(3'd2, 8'h01);
        @(negedge clk);
        check("R7 start strobe", adc_start, 1);
        check("R7 chan", adc_chan, 1);
        sfr_read(3'd2, v); check("R4 start self-clear", v, 0);
        check("R7 strobe width", adc_start, 0);
        sfr_read(3'd1, v); check("R7 busy", v, 8'h02);
        monitor_result("R9");
        check("R12 irq on", irq, 1);

        // R11: clear by writing 0, writing 1 does nothing
        sfr_write(3'd1, 8'h00); sfr_read(3'd1, v); check("R11 clear", v, 0);
        check("R12 irq off", irq, 0);
        sfr_write(3'd1, 8'h01); sfr_read(3'd1, v); check("R11 write one", v, 0);

        // R10: 8-bit format on channel 2, then 10-bit on channel 3 at /16
        sfr_write(3'd0, ctrl_byte(0, 2, 1, 1, 0));
        push_expect(2, 1); sfr_write(3'd2, 8'h01); monitor_result("R10");
        check("R12 irq disabled", irq, 0);
        sfr_write(3'd0, ctrl_byte(0, 2, 1, 1, 1));
        check("R12 irq enabled late", irq, 1);

        // R11: new launch clears done
        sfr_write(3'd0, ctrl_byte(0, 3, 3, 0, 0));
        push_expect(3, 0); sfr_write(3'd2, 8'h01);
        @(negedge clk);
        sfr_read(3'd1, v); check("R11 launch clears done", v, 8'h02);
        monitor_result("R9 ch3");
        sfr_write(3'd0, ctrl_byte(0, 0, 2, 1, 0));
        push_expect(0, 1); sfr_write(3'd2, 8'h01); monitor_result("R10 ch0");

        // R5: hardware edge in hardware mode
        sfr_write(3'd1, 8'h00);
        sfr_write(3'd0, ctrl_byte(1, 2, 0, 0, 0));
        push_expect(2, 0); pulse_hw(); monitor_result("R5");
        // R4: start write ignored in hardware mode
        sfr_write(3'd1, 8'h00);
        sfr_write(3'd2, 8'h01);
        sfr_read(3'd2, v); check("R4 hw mode start", v, 0);
        expect_idle_no_done("R4 hw mode no conv");
        // R5: hw_trig ignored in software mode
        sfr_write(3'd0, ctrl_byte(0, 2, 0, 0, 0));
        pulse_hw();
        expect_idle_no_done("R5 sw mode ignores hw");

        // R6: PWM triggering
        sfr_write(3'd5, 8'h03);
        sfr_read(3'd5, v); check("R6 setup readback", v, 8'h03);
        pulse_pwm(2'b01);
        expect_idle_no_done("R6 other channel");
        push_expect(2, 0); pulse_pwm(2'b10); monitor_result("R6 sw mode");
        sfr_write(3'd0, ctrl_byte(1, 1, 0, 1, 0));
        push_expect(1, 1); pulse_pwm(2'b10); monitor_result("R6 hw mode");
        sfr_write(3'd1, 8'h00);
        sfr_write(3'd5, 8'h02);
        pulse_pwm(2'b10);
        expect_idle_no_done("R6 disabled");

        // R8: triggers while busy are ignored
        sfr_write(3'd5, 8'h01);
        sfr_write(3'd0, ctrl_byte(0, 3, 3, 0, 0));
        push_expect(3, 0); sfr_write(3'd2, 8'h01);
        repeat (20) @(negedge clk);
        pulse_pwm(2'b01);
        sfr_write(3'd2, 8'h01);
        sfr_read(3'd2, v); check("R8 start while busy", v, 0);
        monitor_result("R8 single");
        sfr_write(3'd1, 8'h00);
        expect_idle_no_done("R8 no second conv");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule